// File: doc/BRIEF.md
# Audio Codec Bring-up Sequencer

This block brings an AC97-style audio codec out of reset and keeps its mixer settings in step with a set of switches. It drives the codec's active-low reset pin low for a programmable number of clock cycles. It then waits for the frame engine to report that the codec is ready. After that it performs a fixed series of register writes: first the PCM sample-rate register, then the speaker and microphone volume registers. From then on it watches the switch-derived register words and writes any word that changes.

The block only produces register-write requests. A separate frame engine owns the serial link and keeps generating frame sync the whole time. That engine takes each request and answers with a one-cycle acknowledge once the command has gone out. At most one request is open at any moment. A sticky done flag tells the audio path that playback and record may begin.

Top module: `codec_boot_seq`

## Requirements
- R1: `codec_rst_n` is 0 while `rst` is high. It rises on the RST_HOLD-th rising clock edge after `rst` is released and stays high until the next `rst`.
- R2: `wr_req` stays low until `codec_rst_n` is high and `codec_ready` has been sampled high. While `codec_rst_n` is low, a high `codec_ready` has no effect.
- R3: The first write after reset goes to address 0x2C with data 0x0FA0 (the PCM sample-rate register).
- R4: The initialization writes come in this fixed order: 0x2C, then the speaker register at 0x02, then the microphone register at 0x0E. Each volume write carries the switch-derived word at the moment that write is issued.
- R5: The attenuation value is 31 minus the 5-bit switch level. The speaker word carries the mute bit in bit 15 and the attenuation in both bits 12:8 and bits 4:0, with every other bit 0. The microphone word carries the mute bit in bit 15 and the attenuation in bits 4:0, with every other bit 0.
- R6: `init_done` rises on the clock edge that takes the acknowledge of the third initialization write, and not before. It then stays high until `rst`, whatever `codec_ready` does afterwards.
- R7: After initialization, when the speaker or microphone word differs from the last word written to that register, the block writes the current word to that register once.
- R8: When neither word has changed since its last write, no write request is made.
- R9: A write completes on a clock edge where `wr_req` and `wr_ack` are both high. Until then `wr_req` stays high, and `wr_addr` and `wr_data` do not change. Only one request is open at a time.
- R10: When both words need a write at once, the speaker register is written first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| codec_ready | input | 1 | Codec-ready status, decoded by the frame engine |
| wr_ack | input | 1 | One-cycle acknowledge from the frame engine |
| spk_level | input | VOL_W | Speaker volume switches, all ones is loudest |
| spk_mute | input | 1 | Speaker mute switch |
| mic_level | input | VOL_W | Microphone gain switches, all ones is loudest |
| mic_mute | input | 1 | Microphone mute switch |
| codec_rst_n | output | 1 | Active-low reset to the codec |
| wr_req | output | 1 | Register-write request to the frame engine |
| wr_addr | output | ADDR_W | Codec register address of the request |
| wr_data | output | DATA_W | Codec register data of the request |
| init_done | output | 1 | Initialization writes acknowledged, so audio may start |

## Verification
The bench measures the exact edge on which the codec reset releases. A timer that is one cycle short or long shows up directly in that measurement. It holds `codec_ready` both low and high across the reset hold, which catches a design that writes too early or ignores the hold. Switch changes are made while a request is held unacknowledged: a design that updates its request in place, or that forgets the later value, writes the wrong data or too few commands. Changes to both channels at once, changes to mute alone, and idle stretches with no change are also covered. These catch a wrong channel order, a lost mute bit, or spurious rewrites.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;

   typedef enum logic [1:0] {
      ST_WAIT,
      ST_INIT,
      ST_RUN
   } seq_state_t;

   localparam logic [7:0] REG_SPK  = 8'h02;
   localparam logic [7:0] REG_MIC  = 8'h0E;
   localparam logic [7:0] REG_RATE = 8'h2C;

   localparam int INIT_WRITES = 3;
   localparam int ATT_W       = 5;
   localparam int WORD_W      = 16;

endpackage

// File: rtl/codec_rst_timer.sv
module codec_rst_timer #(
   parameter int HOLD = 32
) (
   input  logic clk,
   input  logic rst,
   output logic released
);
   localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("codec_rst_timer: HOLD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt      <= '0;
         released <= 1'b0;
      end else if (!released) begin
         if (cnt == LAST) begin
            released <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/codec_vol_fmt.sv
module codec_vol_fmt
   import codec_boot_pkg::*;
#(
   parameter int VOL_W  = 5,
   parameter bit STEREO = 1'b1
) (
   input  logic [VOL_W-1:0]  level,
   input  logic              mute,
   output logic [WORD_W-1:0] word
);
   localparam int PAD = ATT_W - VOL_W;

   logic [ATT_W-1:0] lvl;
   logic [ATT_W-1:0] att;

   generate
      if (VOL_W < 1 || VOL_W > ATT_W) begin : g_bad_width
         $error("codec_vol_fmt: VOL_W must be 1..5");
      end
      if (PAD == 0) begin : g_full
         assign lvl = level;
      end else begin : g_padded
         assign lvl = {level, {PAD{1'b0}}};
      end
   endgenerate

   assign att = ~lvl;

   generate
      if (STEREO) begin : g_stereo
         assign word = {mute, 2'b00, att, 3'b000, att};
      end else begin : g_mono
         assign word = {mute, 10'b0, att};
      end
   endgenerate
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
   import codec_boot_pkg::*;
#(
   parameter int              RST_HOLD   = 32,
   parameter int              VOL_W      = 5,
   parameter int              ADDR_W     = 8,
   parameter int              DATA_W     = 16,
   parameter logic [15:0]     RATE_VALUE = 16'h0FA0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              codec_ready,
   input  logic              wr_ack,
   input  logic [VOL_W-1:0]  spk_level,
   input  logic              spk_mute,
   input  logic [VOL_W-1:0]  mic_level,
   input  logic              mic_mute,
   output logic              codec_rst_n,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              init_done
);
   localparam logic [1:0] LAST_IDX = 2'(INIT_WRITES - 1);

   generate
      if (DATA_W != WORD_W) begin : g_bad_data
         $error("codec_boot_seq: DATA_W must be 16");
      end
      if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
         $error("codec_boot_seq: ADDR_W must be 6..8");
      end
   endgenerate

   // reset hold timer
   logic released;

   codec_rst_timer #(.HOLD(RST_HOLD)) u_rst_timer (
      .clk      (clk),
      .rst      (rst),
      .released (released)
   );

   assign codec_rst_n = released;

   // switch to register word mapping
   logic [WORD_W-1:0] spk_word;
   logic [WORD_W-1:0] mic_word;

   codec_vol_fmt #(.VOL_W(VOL_W), .STEREO(1'b1)) u_spk_fmt (
      .level (spk_level),
      .mute  (spk_mute),
      .word  (spk_word)
   );

   codec_vol_fmt #(.VOL_W(VOL_W), .STEREO(1'b0)) u_mic_fmt (
      .level (mic_level),
      .mute  (mic_mute),
      .word  (mic_word)
   );

   // sequencing state
   seq_state_t        state;
   logic [1:0]        idx;
   logic [WORD_W-1:0] spk_last;
   logic [WORD_W-1:0] mic_last;

   logic [1:0]        load_sel;
   logic [ADDR_W-1:0] load_addr;
   logic [DATA_W-1:0] load_data;
   logic              ack_take;

   assign ack_take = wr_req && wr_ack;

   always_comb begin
      load_sel = (state == ST_WAIT) ? 2'd0 : idx + 2'd1;
      case (load_sel)
         2'd0: begin
            load_addr = ADDR_W'(REG_RATE);
            load_data = RATE_VALUE;
         end
         2'd1: begin
            load_addr = ADDR_W'(REG_SPK);
            load_data = spk_word;
         end
         default: begin
            load_addr = ADDR_W'(REG_MIC);
            load_data = mic_word;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_WAIT;
         idx       <= '0;
         wr_req    <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         init_done <= 1'b0;
         spk_last  <= '0;
         mic_last  <= '0;
      end else begin
         case (state)
            ST_WAIT: begin
               if (released && codec_ready) begin
                  wr_req  <= 1'b1;
                  wr_addr <= load_addr;
                  wr_data <= load_data;
                  idx     <= '0;
                  state   <= ST_INIT;
               end
            end
            ST_INIT: begin
               if (ack_take) begin
                  if (idx == LAST_IDX) begin
                     wr_req    <= 1'b0;
                     init_done <= 1'b1;
                     state     <= ST_RUN;
                  end else begin
                     idx     <= idx + 2'd1;
                     wr_addr <= load_addr;
                     wr_data <= load_data;
                     if (load_sel == 2'd1) spk_last <= spk_word;
                     if (load_sel == 2'd2) mic_last <= mic_word;
                  end
               end
            end
            ST_RUN: begin
               if (wr_req) begin
                  if (wr_ack) wr_req <= 1'b0;
               end else if (spk_word != spk_last) begin
                  wr_req   <= 1'b1;
                  wr_addr  <= ADDR_W'(REG_SPK);
                  wr_data  <= spk_word;
                  spk_last <= spk_word;
               end else if (mic_word != mic_last) begin
                  wr_req   <= 1'b1;
                  wr_addr  <= ADDR_W'(REG_MIC);
                  wr_data  <= mic_word;
                  mic_last <= mic_word;
               end
            end
            default: state <= ST_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/codec_boot_chk.sv
module codec_boot_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              codec_rst_n,
   input logic              wr_req,
   input logic              wr_ack,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              init_done
);
   // R1
   rst_release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $past(codec_rst_n) |-> codec_rst_n);

   // R2
   no_early_req_chk: assert property (@(posedge clk) disable iff (rst)
      !codec_rst_n |-> !wr_req);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

   // R9
   req_drop_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(wr_req) |-> $past(wr_ack));

   // R6
   done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   // R6
   done_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(init_done) |-> $past(wr_req && wr_ack));
endmodule

bind codec_boot_seq codec_boot_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_boot_chk (.*);

// File: tb/test_codec_boot_seq.sv
module test_codec_boot_seq;
   localparam int HOLD = 24;
   localparam int VW   = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          codec_ready = 1'b0;
   logic          wr_ack = 1'b0;
   logic [VW-1:0] spk_level = '0;
   logic          spk_mute = 1'b0;
   logic [VW-1:0] mic_level = '0;
   logic          mic_mute = 1'b0;
   logic          codec_rst_n;
   logic          wr_req;
   logic [7:0]    wr_addr;
   logic [15:0]   wr_data;
   logic          init_done;

   int   n_chk = 0;
   int   n_bad = 0;
   logic [7:0]  lg_addr [256];
   logic [15:0] lg_data [256];
   logic        lg_post [256];
   int   n_log = 0;
   bit   hold_ack = 1'b0;
   bit   req_seen = 1'b0;
   logic [15:0] exp_spk;
   logic [15:0] exp_mic;

   codec_boot_seq #(.RST_HOLD(HOLD), .VOL_W(VW)) i_codec_boot_seq (
      .clk         (clk),
      .rst         (rst),
      .codec_ready (codec_ready),
      .wr_ack      (wr_ack),
      .spk_level   (spk_level),
      .spk_mute    (spk_mute),
      .mic_level   (mic_level),
      .mic_mute    (mic_mute),
      .codec_rst_n (codec_rst_n),
      .wr_req      (wr_req),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .init_done   (init_done)
   );

   initial forever #5 clk = ~clk;

   function automatic logic [15:0] spk_fmt(logic [VW-1:0] l, logic m);
      logic [4:0] a;
      a = 5'(31 - int'(l));
      return {m, 2'b00, a, 3'b000, a};
   endfunction

   function automatic logic [15:0] mic_fmt(logic [VW-1:0] l, logic m);
      logic [4:0] a;
      a = 5'(31 - int'(l));
      return {m, 10'b0, a};
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // frame engine model: acknowledges after a random delay
   initial begin
      int wt;
      wt = 0;
      forever begin
         @(negedge clk);
         if (wr_req) req_seen = 1'b1;
         if (wr_ack) begin
            wr_ack = 1'b0;
            lg_post[n_log-1] = init_done;
         end else if (wr_req && !hold_ack && n_log < 256) begin
            if (wt == 0) begin
               lg_addr[n_log] = wr_addr;
               lg_data[n_log] = wr_data;
               n_log++;
               wr_ack = 1'b1;
               wt = int'($urandom % 4);
            end else begin
               wt--;
            end
         end
      end
   end

   task automatic check_init(int b);
      logic [7:0]  ea [3];
      logic [15:0] ed [3];
      ea[0] = 8'h2C; ed[0] = 16'h0FA0;
      ea[1] = 8'h02; ed[1] = spk_fmt(spk_level, spk_mute);
      ea[2] = 8'h0E; ed[2] = mic_fmt(mic_level, mic_mute);
      check(n_log - b == 3, "R4 init write count", n_log - b, 3);
      for (int i = 0; i < 3; i++) begin
         check({lg_addr[b+i], lg_data[b+i]} == {ea[i], ed[i]},
               (i == 0) ? "R3 rate write" : "R4 R5 init volume write",
               int'({lg_addr[b+i], lg_data[b+i]}), int'({ea[i], ed[i]}));
         check(lg_post[b+i] == (i == 2), "R6 done timing",
               int'(lg_post[b+i]), int'(i == 2));
      end
      exp_spk = ed[1];
      exp_mic = ed[2];
   endtask

   task automatic apply(logic [VW-1:0] sl, logic sm, logic [VW-1:0] ml, logic mm);
      int b, k;
      logic [15:0] ns, nm;
      b = n_log;
      spk_level = sl; spk_mute = sm; mic_level = ml; mic_mute = mm;
      ns = spk_fmt(sl, sm);
      nm = mic_fmt(ml, mm);
      settle(25);
      k = b;
      if (ns != exp_spk) begin
         check(n_log > k && {lg_addr[k], lg_data[k]} == {8'h02, ns},
               "R7 R10 speaker update", int'({lg_addr[k], lg_data[k]}), int'({8'h02, ns}));
         k++;
      end
      if (nm != exp_mic) begin
         check(n_log > k && {lg_addr[k], lg_data[k]} == {8'h0E, nm},
               "R7 microphone update", int'({lg_addr[k], lg_data[k]}), int'({8'h0E, nm}));
         k++;
      end
      check(n_log == k, "R8 write count", n_log - b, k - b);
      exp_spk = ns;
      exp_mic = nm;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      int low, b, seed;
      logic [VW-1:0] a_lvl, b_lvl;
      seed = int'($urandom(32'h1D5E));
      spk_level = VW'($urandom);
      mic_level = VW'($urandom);
      settle(4);
      // R1 R2 R6 reset state
      check(codec_rst_n == 1'b0, "R1 reset low", int'(codec_rst_n), 0);
      check(wr_req == 1'b0, "R2 no request in reset", int'(wr_req), 0);
      check(init_done == 1'b0, "R6 done clear", int'(init_done), 0);

      rst = 1'b0;
      low = 0;
      @(negedge clk);
      while (!codec_rst_n && low < 1000) begin
         low++;
         @(negedge clk);
      end
      // R1: rises on edge HOLD, so HOLD-1 low samples after release
      check(low == HOLD - 1, "R1 hold length", low, HOLD - 1);

      settle(40);
      check(!req_seen && n_log == 0, "R2 wait for ready", n_log, 0);
      check(codec_rst_n == 1'b1, "R1 stays released", int'(codec_rst_n), 1);

      codec_ready = 1'b1;
      for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
      settle(3);
      check_init(0);

      b = n_log;
      settle(30);
      check(n_log == b, "R8 idle", n_log - b, 0);

      codec_ready = 1'b0;
      settle(20);
      check(init_done == 1'b1, "R6 sticky done", int'(init_done), 1);
      check(n_log == b, "R8 ready drop", n_log - b, 0);

      for (int it = 0; it < 40; it++) begin
         case ($urandom % 5)
            0: apply(VW'($urandom), spk_mute, mic_level, mic_mute);
            1: apply(spk_level, spk_mute, VW'($urandom), mic_mute);
            2: apply(VW'($urandom), spk_mute, VW'($urandom), mic_mute);
            3: apply(spk_level, ~spk_mute, mic_level, ~mic_mute);
            default: apply(spk_level, spk_mute, mic_level, mic_mute);
         endcase
      end

      // R10 both channels change together
      apply(spk_level ^ VW'(1), spk_mute, mic_level ^ VW'(3), mic_mute);
      // R5 mute bit only
      apply(spk_level, ~spk_mute, mic_level, mic_mute);
      apply(spk_level, spk_mute, mic_level, ~mic_mute);
      // R5 extreme levels
      apply('0, 1'b0, '1, 1'b0);
      apply('1, 1'b1, '0, 1'b1);

      // R9 change while a request is outstanding
      hold_ack = 1'b1;
      a_lvl = spk_level ^ VW'(5);
      b_lvl = spk_level ^ VW'(10);
      spk_level = a_lvl;
      for (int i = 0; i < 10 && !wr_req; i++) @(negedge clk);
      check(wr_req && wr_data == spk_fmt(a_lvl, spk_mute), "R9 request issued",
            int'(wr_data), int'(spk_fmt(a_lvl, spk_mute)));
      spk_level = b_lvl;
      settle(10);
      check(wr_req && {wr_addr, wr_data} == {8'h02, spk_fmt(a_lvl, spk_mute)},
            "R9 request held stable", int'({wr_addr, wr_data}),
            int'({8'h02, spk_fmt(a_lvl, spk_mute)}));
      b = n_log;
      hold_ack = 1'b0;
      settle(30);
      check(n_log == b + 2, "R9 one at a time", n_log - b, 2);
      check(lg_data[b] == spk_fmt(a_lvl, spk_mute), "R9 first value",
            int'(lg_data[b]), int'(spk_fmt(a_lvl, spk_mute)));
      check({lg_addr[b+1], lg_data[b+1]} == {8'h02, spk_fmt(b_lvl, spk_mute)},
            "R7 later value", int'({lg_addr[b+1], lg_data[b+1]}),
            int'({8'h02, spk_fmt(b_lvl, spk_mute)}));

      // second reset with ready already high
      codec_ready = 1'b1;
      rst = 1'b1;
      settle(3);
      check(init_done == 1'b0, "R6 cleared by reset", int'(init_done), 0);
      check(codec_rst_n == 1'b0, "R1 reset asserted again", int'(codec_rst_n), 0);
      b = n_log;
      req_seen = 1'b0;
      rst = 1'b0;
      for (int i = 0; i < 1000 && !codec_rst_n; i++) @(negedge clk);
      check(!req_seen && n_log == b, "R2 ready during hold ignored", n_log - b, 0);
      for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
      settle(3);
      check_init(b);

      summary();
      $finish;
   end
endmodule